// File: doc/BRIEF.md
# Associative Translation Buffer with Address-Space Matching

This block holds a small set of page translations and answers, in the same cycle, whether a virtual page number is currently mapped. Every slot carries a tag (the virtual page number), a physical page number, an 8-bit address-space number, a global flag, a read-enable and a write-enable mask with one bit per privilege mode, a fault-on-read and a fault-on-write flag, and a valid bit. Any slot can hold any page. A slot answers a lookup only for the address space it was loaded under, unless its global flag is set, in which case it answers for every address space.

New translations arrive on a valid/ready insert port and always land in the slot named by a replacement pointer. Software reads that pointer, together with the slot it names, and can step it forward by setting the advance input on a read. Three invalidation commands share one command input: clear everything, clear everything not marked global, and clear the slots that match one page under the lookup rule. A command takes effect on the clock edge that ends the cycle in which it is driven. While a command is driven, the insert port applies back-pressure: `ins_ready` is low, and an insert offered in that cycle is not taken. The sender keeps `ins_valid` and its data steady until a cycle where ready is high.

Top module: `tlb_assoc`

## Requirements
- R1: After reset every slot is invalid, the replacement pointer is 0, `lk_hit` is 0 and `rp_valid` is 0.
- R2: `lk_hit` is 1 in the same cycle as `lk_vpn`/`lk_asn` exactly when some slot is valid, its tag equals `lk_vpn`, and either its global flag is set or its stored number equals `lk_asn`. `lk_ppn` and the permission outputs then come from that slot.
- R3: When several slots hit, `lk_idx` names the lowest-numbered one.
- R4: An insert is taken when `ins_valid` and `ins_ready` are both 1. It writes the slot at the replacement pointer, replacing whatever that slot held, and is visible to lookups from the next cycle. An insert does not move the pointer.
- R5: `rp_idx` shows the pointer, and `rp_valid`, `rp_vpn`, `rp_ppn`, `rp_asn` and `rp_glob` show the slot it names. With `rp_rd` and `rp_adv` both 1, the pointer steps by one on the edge, and it wraps from ENTRIES-1 to 0. `rp_adv` without `rp_rd` leaves the pointer unchanged.
- R6: `fl_cmd` = 1 (clear all) invalidates every slot on the edge.
- R7: `fl_cmd` = 2 (clear local) invalidates only the slots whose global flag is 0. Global slots survive.
- R8: `fl_cmd` = 3 (clear page) invalidates every slot that `fl_vpn`/`fl_asn` would hit under the rule of R2, and no other slot.
- R9: While `fl_cmd` is non-zero, `ins_ready` is 0 and no insert is written. The command alone changes the table in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | 30 | Lookup virtual page number |
| lk_asn | input | 8 | Current address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Slot that hit (lowest) |
| lk_ppn | output | 28 | Physical page of hit slot |
| lk_rd_en | output | 4 | Read-enable mask per mode of hit slot |
| lk_wr_en | output | 4 | Write-enable mask per mode of hit slot |
| lk_fonr | output | 1 | Fault-on-read flag of hit slot |
| lk_fonw | output | 1 | Fault-on-write flag of hit slot |
| ins_valid | input | 1 | Insert offered |
| ins_ready | output | 1 | Insert can be taken this cycle |
| ins_vpn | input | 30 | Insert tag |
| ins_ppn | input | 28 | Insert physical page |
| ins_asn | input | 8 | Insert address-space number |
| ins_glob | input | 1 | Insert global flag |
| ins_rd_en | input | 4 | Insert read-enable mask |
| ins_wr_en | input | 4 | Insert write-enable mask |
| ins_fonr | input | 1 | Insert fault-on-read flag |
| ins_fonw | input | 1 | Insert fault-on-write flag |
| fl_cmd | input | 2 | 0 none, 1 clear all, 2 clear local, 3 clear page |
| fl_vpn | input | 30 | Page for clear-page |
| fl_asn | input | 8 | Address-space number for clear-page |
| rp_rd | input | 1 | Pointer read |
| rp_adv | input | 1 | Step pointer on a read |
| rp_idx | output | IDX_W | Replacement pointer |
| rp_valid | output | 1 | Valid bit of slot at pointer |
| rp_vpn | output | 30 | Tag of slot at pointer |
| rp_ppn | output | 28 | Physical page of slot at pointer |
| rp_asn | output | 8 | Address-space number of slot at pointer |
| rp_glob | output | 1 | Global flag of slot at pointer |

## Verification
An invalidation command and an insert can be offered in the same cycle. The bench drives a clear-local command together with an insert of a fresh non-global page. It expects `ins_ready` to be low in that cycle. Afterwards it expects the offered page to miss, the non-global slots to be gone and the global slot to still hit. All expected lookup results come from a shadow table kept in the bench, which the bench updates with the same priority rule.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W     = 43;
  localparam int PG_OFF_W = 13;
  localparam int VPN_W    = VA_W - PG_OFF_W;
  localparam int PPN_W    = 28;
  localparam int ASN_W    = 8;
  localparam int MODE_N   = 4;

  typedef struct packed {
    logic              vld;
    logic [VPN_W-1:0]  tag;
    logic [PPN_W-1:0]  ppn;
    logic [ASN_W-1:0]  asn;
    logic              glob;
    logic [MODE_N-1:0] rd_en;
    logic [MODE_N-1:0] wr_en;
    logic              fonr;
    logic              fonw;
  } tlb_ent_t;

  typedef enum logic [1:0] {
    FL_NONE  = 2'd0,
    FL_ALL   = 2'd1,
    FL_LOCAL = 2'd2,
    FL_ADDR  = 2'd3
  } fl_cmd_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 48
) (
  input  logic [ENTRIES-1:0]            vld,
  input  logic [ENTRIES-1:0]            glob,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
  input  logic [ENTRIES-1:0][ASN_W-1:0] asns,
  input  logic [VPN_W-1:0]              vpn,
  input  logic [ASN_W-1:0]              asn,
  output logic [ENTRIES-1:0]            hit_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] && (tags[g] == vpn) && (glob[g] || (asns[g] == asn));
  end
endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
  parameter int N = 48,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/tlb_repl.sv
module tlb_repl #(
  parameter int ENTRIES = 48,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (step) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ptr));
  a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 48,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASN_W-1:0]  lk_asn,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [MODE_N-1:0] lk_rd_en,
  output logic [MODE_N-1:0] lk_wr_en,
  output logic              lk_fonr,
  output logic              lk_fonw,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [VPN_W-1:0]  ins_vpn,
  input  logic [PPN_W-1:0]  ins_ppn,
  input  logic [ASN_W-1:0]  ins_asn,
  input  logic              ins_glob,
  input  logic [MODE_N-1:0] ins_rd_en,
  input  logic [MODE_N-1:0] ins_wr_en,
  input  logic              ins_fonr,
  input  logic              ins_fonw,
  input  logic [1:0]        fl_cmd,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [ASN_W-1:0]  fl_asn,
  input  logic              rp_rd,
  input  logic              rp_adv,
  output logic [IDX_W-1:0]  rp_idx,
  output logic              rp_valid,
  output logic [VPN_W-1:0]  rp_vpn,
  output logic [PPN_W-1:0]  rp_ppn,
  output logic [ASN_W-1:0]  rp_asn,
  output logic              rp_glob
);
  tlb_ent_t [ENTRIES-1:0]      ents;
  logic [ENTRIES-1:0]          vld_vec, glob_vec, lk_vec, fl_vec;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_arr;
  logic [ENTRIES-1:0][ASN_W-1:0] asn_arr;
  logic [IDX_W-1:0]            ptr;
  tlb_ent_t                    new_ent;
  fl_cmd_e                     cmd;
  logic                        ins_fire;

  assign cmd       = fl_cmd_e'(fl_cmd);
  assign ins_ready = (cmd == FL_NONE);
  assign ins_fire  = ins_valid && ins_ready;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_unpack
    assign vld_vec[g]  = ents[g].vld;
    assign glob_vec[g] = ents[g].glob;
    assign tag_arr[g]  = ents[g].tag;
    assign asn_arr[g]  = ents[g].asn;
  end

  tlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
    .vld(vld_vec), .glob(glob_vec), .tags(tag_arr), .asns(asn_arr),
    .vpn(lk_vpn), .asn(lk_asn), .hit_vec(lk_vec));

  tlb_match #(.ENTRIES(ENTRIES)) u_fl_match (
    .vld(vld_vec), .glob(glob_vec), .tags(tag_arr), .asns(asn_arr),
    .vpn(fl_vpn), .asn(fl_asn), .hit_vec(fl_vec));

  tlb_prio #(.N(ENTRIES)) u_prio (.vec(lk_vec), .any(lk_hit), .idx(lk_idx));

  tlb_repl #(.ENTRIES(ENTRIES)) u_repl (
    .clk(clk), .rst_n(rst_n), .step(rp_rd && rp_adv), .ptr(ptr));

  always_comb begin
    new_ent.vld   = 1'b1;
    new_ent.tag   = ins_vpn;
    new_ent.ppn   = ins_ppn;
    new_ent.asn   = ins_asn;
    new_ent.glob  = ins_glob;
    new_ent.rd_en = ins_rd_en;
    new_ent.wr_en = ins_wr_en;
    new_ent.fonr  = ins_fonr;
    new_ent.fonw  = ins_fonw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ents <= '0;
    end else begin
      unique case (cmd)
        FL_ALL:   for (int i = 0; i < ENTRIES; i++) ents[i].vld <= 1'b0;
        FL_LOCAL: for (int i = 0; i < ENTRIES; i++) if (!ents[i].glob) ents[i].vld <= 1'b0;
        FL_ADDR:  for (int i = 0; i < ENTRIES; i++) if (fl_vec[i]) ents[i].vld <= 1'b0;
        default:  if (ins_fire) ents[ptr] <= new_ent;
      endcase
    end
  end

  assign lk_ppn   = ents[lk_idx].ppn;
  assign lk_rd_en = ents[lk_idx].rd_en;
  assign lk_wr_en = ents[lk_idx].wr_en;
  assign lk_fonr  = ents[lk_idx].fonr;
  assign lk_fonw  = ents[lk_idx].fonw;

  assign rp_idx   = ptr;
  assign rp_valid = ents[ptr].vld;
  assign rp_vpn   = ents[ptr].tag;
  assign rp_ppn   = ents[ptr].ppn;
  assign rp_asn   = ents[ptr].asn;
  assign rp_glob  = ents[ptr].glob;

  // R2: the slot reported by the encoder really satisfies the hit rule
  a_r2_hit_rule: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (ents[lk_idx].vld && ents[lk_idx].tag == lk_vpn &&
                (ents[lk_idx].glob || ents[lk_idx].asn == lk_asn)));
  // R3: no lower slot also matched
  a_r3_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ((lk_vec & ~({ENTRIES{1'b1}} << lk_idx)) == '0));
  // R4: an accepted insert is present at the old pointer
  a_r4_insert: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire |=> (ents[$past(ptr)].vld && ents[$past(ptr)].tag == $past(ins_vpn)));
  // R6
  a_r6_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == FL_ALL) |=> (vld_vec == '0));
  // R7
  a_r7_clear_local: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == FL_LOCAL) |=> ((vld_vec & ~glob_vec) == '0));
  // R9: a command cycle never adds a valid slot
  a_r9_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != FL_NONE) |=> ($countones(vld_vec) <= $past($countones(vld_vec))));
endmodule

// File: tb/tlb_assoc_test.sv
module tlb_assoc_test;
  import tlb_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0, ins_vpn = '0, fl_vpn = '0;
  logic [ASN_W-1:0] lk_asn = '0, ins_asn = '0, fl_asn = '0;
  logic [PPN_W-1:0] ins_ppn = '0;
  logic ins_valid = 1'b0, ins_glob = 1'b0, rp_rd = 1'b0, rp_adv = 1'b0;
  logic [1:0] fl_cmd = 2'd0;
  logic lk_hit, lk_fonr, lk_fonw, ins_ready, rp_valid, rp_glob;
  logic [IW-1:0] lk_idx, rp_idx;
  logic [PPN_W-1:0] lk_ppn, rp_ppn;
  logic [MODE_N-1:0] lk_rd_en, lk_wr_en;
  logic [VPN_W-1:0] rp_vpn;
  logic [ASN_W-1:0] rp_asn;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_assoc #(.ENTRIES(N)) uut (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en),
    .lk_wr_en(lk_wr_en), .lk_fonr(lk_fonr), .lk_fonw(lk_fonw),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_vpn(ins_vpn),
    .ins_ppn(ins_ppn), .ins_asn(ins_asn), .ins_glob(ins_glob),
    .ins_rd_en(4'hF), .ins_wr_en(4'h3), .ins_fonr(1'b0), .ins_fonw(1'b1),
    .fl_cmd(fl_cmd), .fl_vpn(fl_vpn), .fl_asn(fl_asn),
    .rp_rd(rp_rd), .rp_adv(rp_adv), .rp_idx(rp_idx), .rp_valid(rp_valid),
    .rp_vpn(rp_vpn), .rp_ppn(rp_ppn), .rp_asn(rp_asn), .rp_glob(rp_glob));

  // shadow table
  bit m_vld[N];
  bit m_glob[N];
  logic [VPN_W-1:0] m_vpn[N];
  logic [ASN_W-1:0] m_asn[N];
  logic [PPN_W-1:0] m_ppn[N];
  int m_ptr = 0;

  // scoreboard queues
  int q_hit[$];
  int q_idx[$];
  longint q_ppn[$];
  string q_req[$];

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_match(int i, logic [VPN_W-1:0] v, logic [ASN_W-1:0] a);
    return m_vld[i] && m_vpn[i] == v && (m_glob[i] || m_asn[i] == a);
  endfunction

  task automatic do_lookup(string req, int v, int a);
    int eh = 0, ei = 0;
    longint ep = 0;
    @(negedge clk);
    lk_vpn = VPN_W'(v);
    lk_asn = ASN_W'(a);
    for (int i = N - 1; i >= 0; i--)
      if (m_match(i, VPN_W'(v), ASN_W'(a))) begin eh = 1; ei = i; ep = longint'(m_ppn[i]); end
    q_hit.push_back(eh); q_idx.push_back(ei); q_ppn.push_back(ep); q_req.push_back(req);
    @(negedge clk);
  endtask

  // monitor: compares after the edge that follows each pushed lookup
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_hit.size() > 0) begin
        int eh, ei;
        longint ep;
        string r;
        eh = q_hit.pop_front(); ei = q_idx.pop_front();
        ep = q_ppn.pop_front(); r = q_req.pop_front();
        chk({r, " hit"}, longint'(lk_hit), longint'(eh));
        if (eh != 0) begin
          chk({r, " idx"}, longint'(lk_idx), longint'(ei));
          chk({r, " ppn"}, longint'(lk_ppn), ep);
        end
      end
    end
  end

  task automatic do_insert(int v, int p, int a, bit g);
    @(negedge clk);
    ins_valid = 1'b1; ins_vpn = VPN_W'(v); ins_ppn = PPN_W'(p);
    ins_asn = ASN_W'(a); ins_glob = g;
    chk("R4 ready", longint'(ins_ready), 1);
    @(negedge clk);
    ins_valid = 1'b0;
    m_vld[m_ptr] = 1; m_vpn[m_ptr] = VPN_W'(v); m_ppn[m_ptr] = PPN_W'(p);
    m_asn[m_ptr] = ASN_W'(a); m_glob[m_ptr] = g;
  endtask

  task automatic m_flush(int c, int v, int a);
    for (int i = 0; i < N; i++) begin
      if (c == 1) m_vld[i] = 0;
      else if (c == 2 && !m_glob[i]) m_vld[i] = 0;
      else if (c == 3 && m_match(i, VPN_W'(v), ASN_W'(a))) m_vld[i] = 0;
    end
  endtask

  task automatic do_flush(int c, int v, int a);
    @(negedge clk);
    fl_cmd = 2'(c); fl_vpn = VPN_W'(v); fl_asn = ASN_W'(a);
    @(negedge clk);
    fl_cmd = 2'd0;
    m_flush(c, v, a);
  endtask

  task automatic do_ptr(bit rd, bit adv);
    @(negedge clk);
    rp_rd = rd; rp_adv = adv;
    @(negedge clk);
    rp_rd = 1'b0; rp_adv = 1'b0;
    if (rd && adv) m_ptr = (m_ptr == N - 1) ? 0 : m_ptr + 1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ptr", longint'(rp_idx), 0);
    chk("R1 slot valid", longint'(rp_valid), 0);
    chk("R1 ready", longint'(ins_ready), 1);
    do_lookup("R1 empty", 'h100, 5);

    // R4 insert at pointer, pointer unmoved; R5 read shows slot
    do_insert('h100, 'h11, 5, 0);
    chk("R4 ptr unmoved", longint'(rp_idx), 0);
    chk("R5 read vpn", longint'(rp_vpn), 'h100);
    chk("R5 read asn", longint'(rp_asn), 5);
    chk("R5 read valid", longint'(rp_valid), 1);
    do_ptr(1, 1);
    chk("R5 step", longint'(rp_idx), 1);
    do_insert('h200, 'h22, 5, 1);
    chk("R5 read glob", longint'(rp_glob), 1);
    do_ptr(1, 1);
    do_insert('h100, 'h33, 7, 0);
    do_ptr(1, 1);
    do_insert('h100, 'h44, 9, 1);
    do_ptr(1, 1);
    chk("R5 ptr4", longint'(rp_idx), 4);
    do_ptr(0, 1);
    chk("R5 adv without rd", longint'(rp_idx), 4);

    // R2 / R3 lookups
    do_lookup("R3 asn5 lowest", 'h100, 5);
    do_lookup("R3 asn7 lowest", 'h100, 7);
    do_lookup("R2 global other asn", 'h100, 1);
    do_lookup("R2 global page", 'h200, 99);
    do_lookup("R2 tag miss", 'h300, 5);

    // R8 clear page: removes slot0 and global slot3, keeps slot2
    do_flush(3, 'h100, 5);
    do_lookup("R8 cleared", 'h100, 5);
    do_lookup("R8 other asn kept", 'h100, 7);
    do_lookup("R8 global gone", 'h100, 1);
    do_lookup("R8 other page kept", 'h200, 5);

    // R9 + R7: clear local together with an insert
    @(negedge clk);
    fl_cmd = 2'd2;
    ins_valid = 1'b1; ins_vpn = VPN_W'('h400); ins_ppn = PPN_W'('h55);
    ins_asn = ASN_W'(5); ins_glob = 1'b0;
    chk("R9 ready low", longint'(ins_ready), 0);
    @(negedge clk);
    fl_cmd = 2'd0; ins_valid = 1'b0;
    m_flush(2, 0, 0);
    chk("R9 slot4 empty", longint'(rp_valid), 0);
    do_lookup("R9 insert dropped", 'h400, 5);
    do_lookup("R7 local gone", 'h100, 7);
    do_lookup("R7 global kept", 'h200, 3);

    // R5 wrap
    for (int k = 0; k < 4; k++) do_ptr(1, 1);
    chk("R5 wrap", longint'(rp_idx), 0);
    do_insert('h500, 'h66, 2, 0);
    do_lookup("R4 after wrap", 'h500, 2);
    do_insert('h600, 'h77, 2, 0);
    do_lookup("R4 replaced gone", 'h500, 2);
    do_lookup("R4 replacement", 'h600, 2);

    // R6 clear all
    do_flush(1, 0, 0);
    do_lookup("R6 global gone", 'h200, 3);
    do_lookup("R6 local gone", 'h600, 2);
    chk("R6 slot valid", longint'(rp_valid), 0);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule